// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block is a small, fully associative translation cache. It maps virtual page numbers to physical page numbers for 4 KB pages. Each slot holds a valid bit, an address space tag, a global flag, a virtual page number and a physical page number. A lookup presents a virtual address together with the current address space number. One clock later the block reports whether the translation was found and, if so, the physical address. The page offset passes through unchanged.

Software loads translations by naming the target slot directly. Three maintenance commands are provided:
- a full flush;
- a flush that drops only non-global slots, used on a context switch;
- an invalidate that removes the slots whose virtual page matches a supplied address.

Because slots carry an address space tag, switching contexts only needs a change of the current address space number. Global slots stay usable across every address space.

Top module: `tlbx_top`

## Requirements
- R1: A lookup strobed with `lk_valid` in cycle t produces `res_valid`=1 in cycle t+1. In every cycle not following a lookup, `res_valid`, `res_hit` and `res_paddr` are all 0.
- R2: A lookup hits when some slot is valid, its virtual page equals `lk_vaddr[31:12]`, and either its tag equals `lk_asid` or its global flag is 1. Otherwise it misses.
- R3: On a hit, `res_paddr[11:0]` equals the looked-up `lk_vaddr[11:0]` and `res_paddr[31:12]` equals the matching slot's physical page.
- R4: On a miss, `res_hit` is 0 and `res_paddr` is 0.
- R5: `wr_en` writes the slot numbered `wr_slot`, makes it valid and replaces its previous contents. No other slot changes.
- R6: `flush_all` clears every valid bit, so every later lookup misses until slots are rewritten.
- R7: `flush_nonglobal` clears the valid bit of every slot whose global flag is 0. Global slots remain valid.
- R8: `inval_en` clears every slot whose virtual page equals `inval_vaddr[31:12]`, whatever its tag. All other slots stay intact.
- R9: When a write coincides with any maintenance command in the same cycle, the maintenance is applied first and the write second, so the written slot ends up valid.
- R10: A lookup issued in the same cycle as a write or maintenance command sees the buffer contents from before that cycle's update.
- R11: When more than one slot matches, the lowest-numbered matching slot supplies the physical page.
- R12: Reset (synchronous, active low) clears all valid bits and all result outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup strobe |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address space number |
| res_valid | output | 1 | Lookup result strobe, one cycle after `lk_valid` |
| res_hit | output | 1 | Translation found |
| res_paddr | output | 32 | Physical address on a hit, zero otherwise |
| wr_en | input | 1 | Load a translation |
| wr_slot | input | 4 | Target slot number |
| wr_vpn | input | 20 | Virtual page number to load |
| wr_ppn | input | 20 | Physical page number to load |
| wr_asid | input | 8 | Address space tag to load |
| wr_global | input | 1 | Global flag to load |
| flush_all | input | 1 | Invalidate every slot |
| flush_nonglobal | input | 1 | Invalidate every non-global slot |
| inval_en | input | 1 | Invalidate slots matching one virtual page |
| inval_vaddr | input | 32 | Address whose page is invalidated |

## Verification
The behaviour most prone to error is a slot load arriving in the same cycle as a full flush, a non-global flush or a single-page invalidate of the same page. The bench drives these pairs in one cycle and then sweeps every slot against several address space numbers. The expected result is that only the newly written slot has survived, beside whatever globals the command spares. A lookup is also issued in the very cycle of a write or flush, and it is judged against the contents from before that cycle.

// File: rtl/tlbx_pkg.sv
// Package: shared defaults and the slot match rule for the tagged translation buffer.
// Assumes 4 KB pages; the page offset width is fixed by that page size.
package tlbx_pkg;
    localparam int DEF_SLOTS  = 16;
    localparam int DEF_VPN_W  = 20;
    localparam int DEF_PPN_W  = 20;
    localparam int DEF_ASID_W = 8;
    localparam int PAGE_OFF_W = 12;

    // Match rule: valid, same page, and same tag unless the slot is global.
    function automatic logic slot_hits(input logic valid, input logic page_eq,
                                       input logic tag_eq, input logic global_f);
        return valid & page_eq & (tag_eq | global_f);
    endfunction
endpackage

// File: rtl/tlbx_wr_decode.sv
// Module: turns a write strobe and slot number into a one-hot slot select.
// Assumes wr_slot is below SLOTS; an out-of-range number selects nothing.
module tlbx_wr_decode #(
    parameter int SLOTS = 16,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_slot,
    output logic [SLOTS-1:0] wr_sel
);
    // One comparator per slot.
    for (genvar g = 0; g < SLOTS; g++) begin : g_dec
        assign wr_sel[g] = wr_en && (wr_slot == IDX_W'(g));
    end
endmodule

// File: rtl/tlbx_slot.sv
// Module: one buffer slot with its storage, maintenance kill logic and lookup compare.
// Assumes maintenance commands act before a same-cycle write to this slot.
module tlbx_slot
    import tlbx_pkg::*;
#(
    parameter int VPN_W  = 20,
    parameter int PPN_W  = 20,
    parameter int ASID_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_global,
    input  logic              flush_all,
    input  logic              flush_nonglobal,
    input  logic              inval_en,
    input  logic [VPN_W-1:0]  inval_vpn,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              match,
    output logic [PPN_W-1:0]  ppn
);
    logic              valid_q;
    logic              global_q;
    logic [VPN_W-1:0]  vpn_q;
    logic [PPN_W-1:0]  ppn_q;
    logic [ASID_W-1:0] asid_q;
    logic              kill;

    // Decide whether any maintenance command drops this slot.
    always_comb begin
        kill = flush_all
             | (flush_nonglobal & ~global_q)
             | (inval_en & (vpn_q == inval_vpn));
    end

    // Valid bit: reset clears, write sets (after maintenance), kill clears.
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid_q <= 1'b0;
        else if (wr_sel)
            valid_q <= 1'b1;
        else if (kill)
            valid_q <= 1'b0;
    end

    // Payload storage, loaded only by a write.
    always_ff @(posedge clk) begin
        if (wr_sel) begin
            global_q <= wr_global;
            vpn_q    <= wr_vpn;
            ppn_q    <= wr_ppn;
            asid_q   <= wr_asid;
        end
    end

    // Lookup compare against the current contents.
    always_comb begin
        match = slot_hits(valid_q, vpn_q == lk_vpn, asid_q == lk_asid, global_q);
        ppn   = ppn_q;
    end
endmodule

// File: rtl/tlbx_select.sv
// Module: picks the lowest-numbered matching slot and forwards its physical page.
// Assumes match bits and pages come from the slots combinationally.
module tlbx_select #(
    parameter int SLOTS = 16,
    parameter int PPN_W = 20
) (
    input  logic [SLOTS-1:0]             match,
    input  logic [SLOTS-1:0][PPN_W-1:0]  ppn_all,
    output logic                         any_hit,
    output logic [PPN_W-1:0]             ppn_sel
);
    // Scan from the top down so the lowest match is the last written.
    always_comb begin
        any_hit = 1'b0;
        ppn_sel = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (match[i]) begin
                any_hit = 1'b1;
                ppn_sel = ppn_all[i];
            end
        end
    end
endmodule

// File: rtl/tlbx_top.sv
// Module: fully associative, address-space-tagged translation buffer for 4 KB pages.
// Lookup results are registered one cycle after the strobe; writes name their slot.
// Assumes lookups read the contents from before the same cycle's write or maintenance.
module tlbx_top
    import tlbx_pkg::*;
#(
    parameter int SLOTS  = DEF_SLOTS,
    parameter int VPN_W  = DEF_VPN_W,
    parameter int PPN_W  = DEF_PPN_W,
    parameter int ASID_W = DEF_ASID_W,
    localparam int IDX_W = $clog2(SLOTS),
    localparam int VA_W  = VPN_W + PAGE_OFF_W,
    localparam int PA_W  = PPN_W + PAGE_OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              res_valid,
    output logic              res_hit,
    output logic [PA_W-1:0]   res_paddr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_slot,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_global,
    input  logic              flush_all,
    input  logic              flush_nonglobal,
    input  logic              inval_en,
    input  logic [VA_W-1:0]   inval_vaddr
);
    logic [SLOTS-1:0]            wr_sel;
    logic [SLOTS-1:0]            match;
    logic [SLOTS-1:0][PPN_W-1:0] ppn_all;
    logic                        any_hit;
    logic [PPN_W-1:0]            ppn_sel;
    logic [VPN_W-1:0]            lk_vpn;
    logic [VPN_W-1:0]            inval_vpn;
    logic [PAGE_OFF_W-1:0]       lk_off;

    // Split addresses into page number and offset.
    always_comb begin
        lk_vpn    = lk_vaddr[VA_W-1:PAGE_OFF_W];
        lk_off    = lk_vaddr[PAGE_OFF_W-1:0];
        inval_vpn = inval_vaddr[VA_W-1:PAGE_OFF_W];
    end

    tlbx_wr_decode #(.SLOTS(SLOTS)) u_dec (
        .wr_en   (wr_en),
        .wr_slot (wr_slot),
        .wr_sel  (wr_sel)
    );

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        tlbx_slot #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W)) u_slot (
            .clk             (clk),
            .rst_n           (rst_n),
            .wr_sel          (wr_sel[g]),
            .wr_vpn          (wr_vpn),
            .wr_ppn          (wr_ppn),
            .wr_asid         (wr_asid),
            .wr_global       (wr_global),
            .flush_all       (flush_all),
            .flush_nonglobal (flush_nonglobal),
            .inval_en        (inval_en),
            .inval_vpn       (inval_vpn),
            .lk_vpn          (lk_vpn),
            .lk_asid         (lk_asid),
            .match           (match[g]),
            .ppn             (ppn_all[g])
        );
    end

    tlbx_select #(.SLOTS(SLOTS), .PPN_W(PPN_W)) u_sel (
        .match   (match),
        .ppn_all (ppn_all),
        .any_hit (any_hit),
        .ppn_sel (ppn_sel)
    );

    // Register the lookup result; outputs are zero on a miss or idle cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_paddr <= '0;
        end else begin
            res_valid <= lk_valid;
            res_hit   <= lk_valid & any_hit;
            res_paddr <= (lk_valid && any_hit) ? {ppn_sel, lk_off} : '0;
        end
    end
endmodule

// File: rtl/tlbx_checker.sv
// Module: port-level properties of the translation buffer, bound to every tlbx_top.
// Assumes synchronous active-low reset; all properties are disabled while it is low.
module tlbx_checker #(
    parameter int IDX_W  = 4,
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8,
    parameter int VA_W   = 32,
    parameter int PA_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [VA_W-1:0]   lk_vaddr,
    input logic [ASID_W-1:0] lk_asid,
    input logic              res_valid,
    input logic              res_hit,
    input logic [PA_W-1:0]   res_paddr,
    input logic              wr_en,
    input logic [VPN_W-1:0]  wr_vpn,
    input logic [ASID_W-1:0] wr_asid,
    input logic              flush_all
);
    assert_result_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!res_valid && !res_hit));
    assert_miss_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_paddr == '0));
    assert_offset_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!res_hit || (res_paddr[11:0] == $past(lk_vaddr[11:0]))));
    assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_all && !wr_en) ##1 lk_valid |=> !res_hit);
    assert_write_then_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en ##1 (lk_valid && lk_vaddr[VA_W-1:12] == $past(wr_vpn)
                   && lk_asid == $past(wr_asid)) |=> res_hit);
endmodule

bind tlbx_top tlbx_checker #(
    .IDX_W(IDX_W), .VPN_W(VPN_W), .ASID_W(ASID_W), .VA_W(VA_W), .PA_W(PA_W)
) u_chk (.*);

// File: tb/tlbx_top_test.sv
`timescale 1ns/1ps
// Bench: drives the buffer cycle by cycle, keeps its own model of the slots built
// from the requirements, and checks every cycle's result outputs against it.
module tlbx_top_test;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_asid = '0;
    logic        res_valid, res_hit;
    logic [31:0] res_paddr;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_slot = '0;
    logic [19:0] wr_vpn = '0, wr_ppn = '0;
    logic [7:0]  wr_asid = '0;
    logic        wr_global = 1'b0;
    logic        flush_all = 1'b0, flush_nonglobal = 1'b0, inval_en = 1'b0;
    logic [31:0] inval_vaddr = '0;

    int checks = 0;
    int fails = 0;
    string req = "R1";

    // Model of slot contents.
    logic        m_v [N];
    logic        m_g [N];
    logic [19:0] m_vpn [N];
    logic [19:0] m_ppn [N];
    logic [7:0]  m_asid [N];

    always #2.5 clk = ~clk;

    tlbx_top uut (.*);

    // Watchdog: a hung run is a failed check and still reaches the summary.
    initial begin
        #(5ns * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    function automatic logic [19:0] vpn_of(int i);
        return 20'(32'h10000 + i * 7);
    endfunction
    function automatic logic [19:0] ppn_of(int i);
        return 20'(32'hA0000 ^ (i * 32'h111));
    endfunction

    task automatic model_lookup(input logic [31:0] va, input logic [7:0] as,
                                output logic h, output logic [31:0] pa);
        h = 1'b0;
        pa = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (m_v[i] && m_vpn[i] == va[31:12] && (m_g[i] || m_asid[i] == as)) begin
                h = 1'b1;
                pa = {m_ppn[i], va[11:0]};
            end
        end
    endtask

    // One clock: predict from pre-edge model, check after the edge, then update model.
    task automatic tick();
        logic        eh;
        logic [31:0] ep;
        logic        had;
        had = lk_valid;
        model_lookup(lk_vaddr, lk_asid, eh, ep);
        if (!had) begin eh = 1'b0; ep = '0; end
        @(negedge clk);
        checks++;
        if (res_valid !== had || res_hit !== eh || res_paddr !== ep) begin
            fails++;
            $display("FAIL %s actual v=%b h=%b pa=%h expected v=%b h=%b pa=%h",
                     req, res_valid, res_hit, res_paddr, had, eh, ep);
        end
        for (int i = 0; i < N; i++) begin
            if (flush_all || (flush_nonglobal && !m_g[i]) ||
                (inval_en && m_vpn[i] == inval_vaddr[31:12]))
                m_v[i] = 1'b0;
        end
        if (wr_en) begin
            m_v[wr_slot] = 1'b1;
            m_g[wr_slot] = wr_global;
            m_vpn[wr_slot] = wr_vpn;
            m_ppn[wr_slot] = wr_ppn;
            m_asid[wr_slot] = wr_asid;
        end
        lk_valid = 1'b0;
        wr_en = 1'b0;
        flush_all = 1'b0;
        flush_nonglobal = 1'b0;
        inval_en = 1'b0;
    endtask

    task automatic write(int s, logic [19:0] v, logic [19:0] p, logic [7:0] a, logic g);
        wr_en = 1'b1; wr_slot = 4'(s); wr_vpn = v; wr_ppn = p; wr_asid = a; wr_global = g;
    endtask

    task automatic look(logic [31:0] va, logic [7:0] a);
        lk_valid = 1'b1; lk_vaddr = va; lk_asid = a;
    endtask

    // Sweep every slot's page against matching and mismatching tags.
    task automatic sweep(string r);
        req = r;
        for (int s = 0; s < N; s++) begin
            for (int a = 2; a < 7; a++) begin
                look({vpn_of(s), 12'(s * 32'h101 + a)}, 8'(a));
                tick();
            end
        end
    endtask

    task automatic fill();
        for (int i = 0; i < N; i++) begin
            write(i, vpn_of(i), ppn_of(i), 8'(i % 4 + 3), (i % 5) == 0);
            tick();
        end
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            m_v[i] = 1'b0; m_g[i] = 1'b0; m_vpn[i] = '0; m_ppn[i] = '0; m_asid[i] = '0;
        end
        // R12: reset state.
        repeat (3) @(negedge clk);
        req = "R12";
        checks++;
        if (res_valid !== 1'b0 || res_hit !== 1'b0 || res_paddr !== '0) begin
            fails++;
            $display("FAIL R12 actual v=%b h=%b pa=%h expected all zero", res_valid, res_hit, res_paddr);
        end
        rst_n = 1'b1;
        sweep("R12");
        // R1: idle cycles keep result outputs quiet.
        req = "R1";
        repeat (3) tick();
        // R2 R3 R4: full table, tag and global matching.
        fill();
        sweep("R2");
        sweep("R3");
        // R5: overwrite slot 3 with a fresh page.
        req = "R5";
        write(3, 20'hFEED0, 20'h12345, 8'h04, 1'b0);
        tick();
        sweep("R5");
        look({20'hFEED0, 12'hABC}, 8'h04); tick();
        look({20'hFEED0, 12'hABC}, 8'h05); tick();
        // R11: duplicate page in slots 9 and 2; slot 2 must win.
        req = "R11";
        write(9, 20'h77777, 20'h99999, 8'h11, 1'b0); tick();
        write(2, 20'h77777, 20'h55555, 8'h11, 1'b0); tick();
        look({20'h77777, 12'h321}, 8'h11); tick();
        // R10: lookup in the same cycle as a write sees old contents.
        req = "R10";
        write(1, 20'hBEEF1, 20'h0F0F0, 8'h22, 1'b0);
        look({20'hBEEF1, 12'h010}, 8'h22); tick();
        look({20'hBEEF1, 12'h010}, 8'h22); tick();
        // R8: invalidate slot 5's page (global) and the duplicate page.
        req = "R8";
        inval_en = 1'b1; inval_vaddr = {vpn_of(5), 12'hFFF};
        look({vpn_of(5), 12'h001}, 8'h09); tick();
        sweep("R8");
        inval_en = 1'b1; inval_vaddr = {20'h77777, 12'h000}; tick();
        look({20'h77777, 12'h321}, 8'h11); tick();
        // R7: non-global flush keeps globals only.
        fill();
        req = "R7";
        flush_nonglobal = 1'b1; tick();
        sweep("R7");
        // R9: flush coincides with a write; the write survives.
        fill();
        req = "R9";
        flush_all = 1'b1; write(7, 20'hC0DE7, 20'hD00D7, 8'h03, 1'b0); tick();
        sweep("R9");
        look({20'hC0DE7, 12'h777}, 8'h03); tick();
        req = "R9";
        inval_en = 1'b1; inval_vaddr = {20'hC0DE7, 12'h0};
        write(7, 20'hC0DE7, 20'h11111, 8'h03, 1'b0); tick();
        look({20'hC0DE7, 12'h777}, 8'h03); tick();
        fill();
        flush_nonglobal = 1'b1; write(8, 20'hAAAAA, 20'hBBBBB, 8'h06, 1'b0); tick();
        sweep("R9");
        look({20'hAAAAA, 12'h444}, 8'h06); tick();
        // R6 and R10: lookup in the flush cycle still hits, afterwards all miss.
        fill();
        req = "R10";
        flush_all = 1'b1; look({vpn_of(4), 12'h004}, 8'h03); tick();
        sweep("R6");
        // R12: reset in mid-run empties a full table.
        fill();
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        for (int i = 0; i < N; i++) m_v[i] = 1'b0;
        rst_n = 1'b1;
        sweep("R12");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule